// File: doc/BRIEF.md
# Scanline IRQ counter

This block counts picture-bus scanline events and raises a level interrupt toward the CPU once a programmed number of events has passed. An event is an edge of address bit 12 seen across successive strobed picture-bus accesses in the pattern-table range (addresses with bit 13 clear). Each event reloads an 8-bit down-counter from a latch or decrements it. A zero result may then set a pending flag that drives the interrupt line.

Software programs the block through a small CPU write port. The register is selected by the CPU address masked with 0xE001. One register holds the reload value. One requests a reload. One enables the interrupt. One disables the interrupt and acknowledges it. A static two-bit input picks one of three behaviours: an early variant, a later variant, and a clone that counts falling edges. The input is captured while reset is held.

Top module: `scanline_irq`

## Requirements
- R1: While reset is held and after it, `irq` is 0. The latch, counter, enable, reload request and stored previous bit-12 value are all cleared.
- R2: Only an access with `pbus_strobe`=1 and `pbus_addr[13]`=0 samples `pbus_addr[12]` and stores it as the previous value. Any other access, or any cycle without a strobe, leaves counter and previous value unchanged.
- R3: A counting event occurs when a qualifying access sees bit 12 go 0 to 1 relative to the stored value, for variant codes 2'b00 (early), 2'b01 (later) and 2'b11 (treated as later). For code 2'b10 (clone), the event occurs when bit 12 goes 1 to 0.
- R4: On an event, the counter loads the latch if the counter is 0 or a reload is requested; otherwise it decrements by one. Every event clears the reload request.
- R5: For the later variant and the clone, an event sets the pending flag when the updated counter is 0 and the enable flag is 1. With enable at 0, no event sets it.
- R6: For the early variant, an updated counter of 0 sets the pending flag, with enable at 1, only when a reload was requested or the counter before the event was odd. A reload from 0 with no request never fires.
- R7: A write is decoded on `cpu_addr & 16'hE001`. 16'hC000 loads `cpu_wdata` into the latch. 16'hC001 sets the reload request. 16'hE000 clears enable and pending. 16'hE001 sets enable. Any other decoded value has no effect.
- R8: `irq` is a level equal to the pending flag. It stays at 1 until a disable write, and an enable write does not clear it.
- R9: The variant code is taken from `variant_sel` only while reset is held. Changes during operation have no effect.
- R10: An access or write sampled at a clock edge takes effect at that edge. When both arrive in the same cycle, the event uses the register values from before the write, and the write is then applied on top. A disable write therefore wins over a firing event, and a reload request written in that cycle survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; variant captured while low |
| variant_sel | input | 2 | 00 early, 01 later, 10 clone, 11 as later |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| pbus_strobe | input | 1 | One picture-bus read or write this cycle |
| pbus_addr | input | 14 | Picture-bus address |
| irq | output | 1 | Level interrupt request |

## Verification
Every CPU write and every strobed bus access is sampled at one rising edge, and `irq` reflects its effect right after that same edge, so no result is due later than one edge after its stimulus. The bench drives inputs and compares on falling edges. Each falling edge therefore sees the outcome of exactly the previous edge. A behavioural model updated on each rising edge is compared with `irq` at every falling edge. Directed checks are placed right after the access that completes a count, and right after the access just before it.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CW  = 8,
  parameter int PAW = 14,
  parameter int CAW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     variant_sel,
  input  logic           cpu_we,
  input  logic [CAW-1:0] cpu_addr,
  input  logic [CW-1:0]  cpu_wdata,
  input  logic           pbus_strobe,
  input  logic [PAW-1:0] pbus_addr,
  output logic           irq
);
  localparam logic [CAW-1:0] MASK    = CAW'(16'hE001);
  localparam logic [CAW-1:0] A_LATCH = CAW'(16'hC000);
  localparam logic [CAW-1:0] A_RLD   = CAW'(16'hC001);
  localparam logic [CAW-1:0] A_DIS   = CAW'(16'hE000);
  localparam logic [CAW-1:0] A_EN    = CAW'(16'hE001);

  logic [1:0]    var_q;
  logic [CW-1:0] latch_q, cnt_q;
  logic          en_q, reload_q, pend_q, prev_q;

  wire           sample = pbus_strobe & ~pbus_addr[13];
  wire           a12    = pbus_addr[12];
  wire           clone  = (var_q == 2'b10);
  wire           early  = (var_q == 2'b00);
  wire           tick   = sample & (clone ? (prev_q & ~a12) : (~prev_q & a12));
  wire [CW-1:0]  cnt_nx = ((cnt_q == '0) || reload_q) ? latch_q : cnt_q - 1'b1;
  wire           fire   = tick & en_q & (cnt_nx == '0) & (~early | cnt_q[0] | reload_q);

  wire [CAW-1:0] sel      = cpu_addr & MASK;
  wire           wr_latch = cpu_we & (sel == A_LATCH);
  wire           wr_rld   = cpu_we & (sel == A_RLD);
  wire           wr_dis   = cpu_we & (sel == A_DIS);
  wire           wr_en    = cpu_we & (sel == A_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_q    <= variant_sel;
      latch_q  <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      reload_q <= 1'b0;
      pend_q   <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      if (sample)   prev_q  <= a12;
      if (tick)     cnt_q   <= cnt_nx;
      if (wr_latch) latch_q <= cpu_wdata;
      if (wr_rld)       reload_q <= 1'b1;
      else if (tick)    reload_q <= 1'b0;
      if (wr_dis)       en_q <= 1'b0;
      else if (wr_en)   en_q <= 1'b1;
      if (wr_dis)       pend_q <= 1'b0;
      else if (fire)    pend_q <= 1'b1;
    end
  end

  assign irq = pend_q;
endmodule

module scanline_irq_chk #(
  parameter int CW  = 8,
  parameter int PAW = 14,
  parameter int CAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_we,
  input logic [CAW-1:0] cpu_addr,
  input logic           pbus_strobe,
  input logic [PAW-1:0] pbus_addr,
  input logic           irq,
  input logic           en_q,
  input logic [CW-1:0]  cnt_q
);
  wire ack = cpu_we && ((cpu_addr & CAW'(16'hE001)) == CAW'(16'hE000));
  wire qual = pbus_strobe && !pbus_addr[13];

  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq && !en_q);
  a_r2_no_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> $stable(cnt_q));
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q));
  a_r2_rise_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(qual));
endmodule

bind scanline_irq scanline_irq_chk #(.CW(CW), .PAW(PAW), .CAW(CAW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .pbus_strobe(pbus_strobe), .pbus_addr(pbus_addr), .irq(irq),
  .en_q(en_q), .cnt_q(cnt_q)
);

// File: tb/test_scanline_irq.sv
module test_scanline_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant_sel = 2'b01;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        pbus_strobe = 1'b0;
  logic [13:0] pbus_addr = '0;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_var, m_latch, m_cnt, m_en, m_rld, m_pend, m_prev;

  scanline_irq i_scanline_irq (.*);

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_var = variant_sel; m_latch = 0; m_cnt = 0; m_en = 0;
      m_rld = 0; m_pend = 0; m_prev = 0;
    end else begin
      int old, hit, code;
      hit = 0;
      if (pbus_strobe && pbus_addr < 14'h2000) begin
        if (m_var == 2) hit = (m_prev == 1 && pbus_addr[12] == 0);
        else            hit = (m_prev == 0 && pbus_addr[12] == 1);
        m_prev = pbus_addr[12];
      end
      if (hit) begin
        old = m_cnt;
        if (old == 0 || m_rld) m_cnt = m_latch; else m_cnt = old - 1;
        if (m_cnt == 0 && m_en) begin
          if (m_var != 0 || m_rld || (old % 2) == 1) m_pend = 1;
        end
        m_rld = 0;
      end
      if (cpu_we) begin
        code = cpu_addr & 16'hE001;
        if (code == 16'hC000) m_latch = cpu_wdata;
        if (code == 16'hC001) m_rld = 1;
        if (code == 16'hE000) begin m_en = 0; m_pend = 0; end
        if (code == 16'hE001) m_en = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_pend[0]) begin
        failures++;
        $display("FAIL R10 model compare: irq actual=%b expected=%0d t=%0t", irq, m_pend, $time);
      end
    end
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: irq actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic pb(input logic [13:0] a);
    @(negedge clk); pbus_strobe = 1; pbus_addr = a;
    @(negedge clk); pbus_strobe = 0;
  endtask

  task automatic up();   pb(14'h0000); pb(14'h1000); endtask
  task automatic down(); pb(14'h1000); pb(14'h0000); endtask

  task automatic do_reset(input logic [1:0] v);
    @(negedge clk); variant_sel = v; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", irq, 1'b0);

    // later variant, latch 3
    wr(16'hC000, 8'd3); wr(16'hC001, 0); wr(16'hE001, 0);
    up(); up(); up();
    chk("R4 R5 not yet zero", irq, 1'b0);
    up();
    chk("R5 fire at zero", irq, 1'b1);
    wr(16'hE001, 0);
    chk("R8 enable keeps pending", irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R8 level held", irq, 1'b1);
    wr(16'hA000, 8'hFF); wr(16'h8000, 8'h00);
    chk("R7 other addresses ignored", irq, 1'b1);
    wr(16'hE000, 0);
    chk("R7 disable clears pending", irq, 1'b0);

    // ignored accesses: counter 0, latch 3
    wr(16'hE003, 0);
    up();
    pb(14'h0000); pb(14'h3000);
    @(negedge clk); pbus_addr = 14'h1000; @(negedge clk);
    pb(14'h1000);
    up();
    chk("R2 ignored accesses gave no event", irq, 1'b0);
    up();
    chk("R2 fire after exactly four events", irq, 1'b1);
    wr(16'hE000, 0);

    // latch 0 later: every event fires without reload
    wr(16'hC002, 8'd0); wr(16'hE001, 0);
    up(); up();
    chk("R5 latch zero fires", irq, 1'b1);
    wr(16'hE000, 0); wr(16'hE001, 0);
    up();
    chk("R5 latch zero fires again", irq, 1'b1);
    wr(16'hE000, 0);

    // same-cycle disable vs firing event
    wr(16'hE001, 0);
    pb(14'h0000);
    @(negedge clk); pbus_strobe = 1; pbus_addr = 14'h1000;
    cpu_we = 1; cpu_addr = 16'hE000;
    @(negedge clk); pbus_strobe = 0; cpu_we = 0;
    chk("R10 disable wins over event", irq, 1'b0);

    // R9: variant change without reset has no effect
    variant_sel = 2'b10;
    wr(16'hE001, 0);
    up();
    chk("R9 still rising edge after select change", irq, 1'b1);
    wr(16'hE000, 0);

    // disabled: no interrupt
    do_reset(2'b01);
    wr(16'hC000, 8'd1); wr(16'hC001, 0);
    up(); up(); up();
    chk("R5 disabled never fires", irq, 1'b0);

    // clone variant: falling edges
    do_reset(2'b10);
    chk("R1 clone reset", irq, 1'b0);
    wr(16'hC000, 8'd2); wr(16'hC001, 0); wr(16'hE001, 0);
    down(); down();
    pb(14'h1000);
    chk("R3 clone rising edge no event", irq, 1'b0);
    pb(14'h0000);
    chk("R3 clone fires on third falling edge", irq, 1'b1);

    // early variant
    do_reset(2'b00);
    wr(16'hC000, 8'd0); wr(16'hC001, 0); wr(16'hE001, 0);
    up();
    chk("R6 early fires on requested reload", irq, 1'b1);
    wr(16'hE000, 0); wr(16'hE001, 0);
    up();
    chk("R6 early natural reload from zero silent", irq, 1'b0);
    wr(16'hC000, 8'd2);
    up(); up();
    chk("R6 early counting down", irq, 1'b0);
    up();
    chk("R6 early fires from odd count", irq, 1'b1);

    // code 11 behaves as later
    do_reset(2'b11);
    wr(16'hE001, 0);
    up();
    chk("R3 code 11 as later variant", irq, 1'b1);

    // reload request written with an event in the same cycle survives
    do_reset(2'b01);
    wr(16'hC000, 8'd2); wr(16'hE001, 0);
    up(); up();
    pb(14'h0000);
    @(negedge clk); pbus_strobe = 1; pbus_addr = 14'h1000;
    cpu_we = 1; cpu_addr = 16'hC001;
    @(negedge clk); pbus_strobe = 0; cpu_we = 0;
    chk("R10 count reached zero with write", irq, 1'b1);
    wr(16'hE000, 0); wr(16'hE001, 0);
    up(); up();
    chk("R4 R10 surviving reload restarted count", irq, 1'b0);
    up();
    chk("R4 reload count completes", irq, 1'b1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule